// File: doc/BRIEF.md
# Daisy-Chain Configuration Bitstream Forwarder

This block sits in one device of a chain of programmable devices that all take their configuration from one serial stream. It samples a data bit on every rising edge of the configuration clock. It finds a fixed sync pattern and reads the 24-bit count of payload bits that follows it. It repeats both of these on its serial output, so that the next device in the chain can lock onto the same stream. It then takes a parameterised number of frames for itself. Each frame is handed to a local configuration memory as one word.

While it loads its own frames, the serial output stays at logic 1. Downstream devices therefore never see a frame start pair that is not meant for them. Once every local frame slot has been filled, the block repeats every further payload bit downstream. It counts every payload bit it receives. When that count equals the length field, the block raises a done flag. From then on it ignores its input.

Top module: `cfg_chain_fwd`

## Requirements
- R1: `din` is sampled on the rising edge of `cclk`, and `dout` changes only on the falling edge of `cclk`, half a cycle after the bit it carries was sampled.
- R2: Before the sync pattern is found, `dout` repeats each sampled bit. The sync pattern is the eight most recent bits equal to 1111_0010, with the earliest bit received as the MSB. Patterns that are close to it but differ do not start a header.
- R3: The 24 bits after the sync pattern form the length field, MSB first, and each of them is also repeated on `dout`.
- R4: From the first payload bit until all local frame slots are used, `dout` is held at 1.
- R5: Each local frame is a start pair (0 then 1) followed by FRAME_BITS data bits, MSB first. A frame with a good start pair is written as one word. `fw_addr` is its arrival index (0 to NUM_FRAMES-1). `fw_en` is high for exactly the one cycle after the rising edge that sampled the last data bit.
- R6: A frame whose start pair is not 0,1 is not written. Its slot index is still used up, and `frame_err` goes high and stays high until reset.
- R7: After NUM_FRAMES frames have been taken, every further payload bit is repeated on `dout`.
- R8: Payload bits are counted starting with the first bit after the length field. `done` rises at the rising edge that samples the bit that makes the count equal to the length field. A length of 0 raises `done` at the edge that samples the last length bit. `done` stays high until reset.
- R9: Once `done` is high, input bits have no effect: `dout` stays 1 and no frame is written.
- R10: While `rst_n` is low and right after it is released, `dout` is 1 and `done`, `frame_err` and `fw_en` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cclk | input | 1 | Configuration bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Serial configuration stream in |
| dout | output | 1 | Serial stream to the next device, updated on falling edges |
| fw_en | output | 1 | One-cycle write strobe to the local configuration memory |
| fw_addr | output | $clog2(NUM_FRAMES) | Frame slot being written |
| fw_data | output | FRAME_BITS | Frame word being written |
| done | output | 1 | The whole chain's payload has been received |
| frame_err | output | 1 | Sticky flag for a frame with a bad start pair |

## Verification
The hardest points to reach are the places where the length count ends exactly on a phase boundary. One is a count that ends on the last data bit of the final local frame, so that the write strobe and `done` rise at the same edge. Another is a count that ends part-way through a local frame. A third is a count of zero. The stimulus builds whole streams from chosen lengths: the exact local-frame total, 50 bits, zero, and random lengths from 1 to 250. A bench model places the expected output bit, write and done edge on each bit index. Bad start pairs in the first and third frames, and a near-miss sync pattern just before the real one, cover the remaining corners.

// File: rtl/cfgfwd_pkg.sv
package cfgfwd_pkg;
    typedef enum logic [2:0] {
        PH_HUNT = 3'd0,
        PH_LEN  = 3'd1,
        PH_LOAD = 3'd2,
        PH_PASS = 3'd3,
        PH_DONE = 3'd4
    } phase_t;
endpackage

// File: rtl/cfg_sync_hunt.sv
// Sliding window over the received bits; flags the sync pattern on the bit
// that completes it.
module cfg_sync_hunt #(
    parameter int PRE_BITS = 8,
    parameter logic [PRE_BITS-1:0] PRE_PATTERN = 8'hF2
) (
    input  logic cclk,
    input  logic rst_n,
    input  logic din,
    output logic match
);
    logic [PRE_BITS-1:0] win_d, win_q;

    always_comb begin
        win_d = {win_q[PRE_BITS-2:0], din};
        match = (win_d == PRE_PATTERN);
    end

    always_ff @(posedge cclk or negedge rst_n) begin
        if (!rst_n) win_q <= '1;
        else        win_q <= win_d;
    end
endmodule

// File: rtl/cfg_frame_asm.sv
// Assembles local frames: checks the start pair, shifts data in and
// issues one write per good frame.
module cfg_frame_asm #(
    parameter int FRAME_BITS = 32,
    parameter int NUM_FRAMES = 4,
    localparam int AW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    localparam int PW = $clog2(FRAME_BITS + 2)
) (
    input  logic                  cclk,
    input  logic                  rst_n,
    input  logic                  en,
    input  logic                  din,
    output logic                  last_frame,
    output logic                  wr_en,
    output logic [AW-1:0]         wr_addr,
    output logic [FRAME_BITS-1:0] wr_data,
    output logic                  err
);
    typedef struct packed {
        logic [PW-1:0]         pos;
        logic [AW-1:0]         idx;
        logic                  bad;
        logic [FRAME_BITS-1:0] sh;
        logic                  we;
        logic [AW-1:0]         wa;
        logic [FRAME_BITS-1:0] wd;
        logic                  err;
    } asm_t;

    asm_t a_d, a_q;
    logic mism;

    always_comb begin
        a_d        = a_q;
        a_d.we     = 1'b0;
        last_frame = 1'b0;
        mism       = 1'b0;
        if (en) begin
            if (a_q.pos == '0) begin
                mism  = din;
                a_d.bad = din;
            end else if (a_q.pos == PW'(1)) begin
                mism  = ~din;
                a_d.bad = a_q.bad | ~din;
            end else begin
                a_d.sh = {a_q.sh[FRAME_BITS-2:0], din};
            end
            if (mism) a_d.err = 1'b1;
            if (a_q.pos == PW'(FRAME_BITS + 1)) begin
                a_d.we     = ~a_q.bad;
                a_d.wa     = a_q.idx;
                a_d.wd     = {a_q.sh[FRAME_BITS-2:0], din};
                a_d.pos    = '0;
                a_d.idx    = a_q.idx + 1'b1;
                last_frame = (a_q.idx == AW'(NUM_FRAMES - 1));
            end else begin
                a_d.pos = a_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge cclk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign wr_en   = a_q.we;
    assign wr_addr = a_q.wa;
    assign wr_data = a_q.wd;
    assign err     = a_q.err;

    // R6
    err_sticky_chk: assert property (@(posedge cclk) disable iff (!rst_n)
        a_q.err |=> a_q.err);

    // R5
    wr_addr_chk: assert property (@(posedge cclk) disable iff (!rst_n)
        a_q.we |-> (a_q.wa <= AW'(NUM_FRAMES - 1)));

    // R5
    wr_pulse_chk: assert property (@(posedge cclk) disable iff (!rst_n)
        a_q.we |=> !a_q.we);
endmodule

// File: rtl/cfg_tx_edge.sv
// Output register clocked on the falling edge of the configuration clock.
module cfg_tx_edge (
    input  logic cclk,
    input  logic rst_n,
    input  logic bit_in,
    output logic bit_out
);
    logic out_d, out_q;

    always_comb out_d = bit_in;

    always_ff @(negedge cclk or negedge rst_n) begin
        if (!rst_n) out_q <= 1'b1;
        else        out_q <= out_d;
    end

    assign bit_out = out_q;
endmodule

// File: rtl/cfg_chain_fwd.sv
module cfg_chain_fwd #(
    parameter int FRAME_BITS = 32,
    parameter int NUM_FRAMES = 4,
    parameter int LEN_BITS   = 24,
    parameter int PRE_BITS   = 8,
    parameter logic [PRE_BITS-1:0] PRE_PATTERN = 8'hF2,
    localparam int AW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
    localparam int HW = $clog2(LEN_BITS)
) (
    input  logic                  cclk,
    input  logic                  rst_n,
    input  logic                  din,
    output logic                  dout,
    output logic                  fw_en,
    output logic [AW-1:0]         fw_addr,
    output logic [FRAME_BITS-1:0] fw_data,
    output logic                  done,
    output logic                  frame_err
);
    import cfgfwd_pkg::*;

    typedef struct packed {
        phase_t              ph;
        logic [HW-1:0]       hcnt;
        logic [LEN_BITS-1:0] len;
        logic [LEN_BITS-1:0] cnt;
        logic                fwd;
        logic                done;
    } ctl_t;

    ctl_t s_d, s_q;
    logic                sync_hit;
    logic                load_en;
    logic                frames_full;
    logic [LEN_BITS-1:0] cnt_inc;
    logic [LEN_BITS-1:0] len_nxt;

    cfg_sync_hunt #(
        .PRE_BITS    (PRE_BITS),
        .PRE_PATTERN (PRE_PATTERN)
    ) u_hunt (
        .cclk  (cclk),
        .rst_n (rst_n),
        .din   (din),
        .match (sync_hit)
    );

    cfg_frame_asm #(
        .FRAME_BITS (FRAME_BITS),
        .NUM_FRAMES (NUM_FRAMES)
    ) u_asm (
        .cclk       (cclk),
        .rst_n      (rst_n),
        .en         (load_en),
        .din        (din),
        .last_frame (frames_full),
        .wr_en      (fw_en),
        .wr_addr    (fw_addr),
        .wr_data    (fw_data),
        .err        (frame_err)
    );

    cfg_tx_edge u_tx (
        .cclk    (cclk),
        .rst_n   (rst_n),
        .bit_in  (s_q.fwd),
        .bit_out (dout)
    );

    always_comb begin
        s_d     = s_q;
        load_en = 1'b0;
        cnt_inc = s_q.cnt + 1'b1;
        len_nxt = {s_q.len[LEN_BITS-2:0], din};
        case (s_q.ph)
            PH_HUNT: begin
                s_d.fwd = din;
                if (sync_hit) begin
                    s_d.ph   = PH_LEN;
                    s_d.hcnt = '0;
                end
            end
            PH_LEN: begin
                s_d.fwd  = din;
                s_d.len  = len_nxt;
                s_d.hcnt = s_q.hcnt + 1'b1;
                if (s_q.hcnt == HW'(LEN_BITS - 1)) begin
                    s_d.cnt = '0;
                    if (len_nxt == '0) begin
                        s_d.ph   = PH_DONE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.ph = PH_LOAD;
                    end
                end
            end
            PH_LOAD: begin
                s_d.fwd = 1'b1;
                load_en = 1'b1;
                s_d.cnt = cnt_inc;
                if (cnt_inc == s_q.len) begin
                    s_d.ph   = PH_DONE;
                    s_d.done = 1'b1;
                end else if (frames_full) begin
                    s_d.ph = PH_PASS;
                end
            end
            PH_PASS: begin
                s_d.fwd = din;
                s_d.cnt = cnt_inc;
                if (cnt_inc == s_q.len) begin
                    s_d.ph   = PH_DONE;
                    s_d.done = 1'b1;
                end
            end
            PH_DONE: begin
                s_d.fwd = 1'b1;
            end
            default: begin
                s_d.ph  = PH_HUNT;
                s_d.fwd = 1'b1;
            end
        endcase
    end

    always_ff @(posedge cclk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.ph   <= PH_HUNT;
            s_q.fwd  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign done = s_q.done;

    // R8
    done_hold_chk: assert property (@(posedge cclk) disable iff (!rst_n)
        s_q.done |=> s_q.done);

    // R8
    done_count_chk: assert property (@(posedge cclk) disable iff (!rst_n)
        $rose(s_q.done) |-> (s_q.cnt == s_q.len));

    // R4
    load_high_chk: assert property (@(posedge cclk) disable iff (!rst_n)
        (s_q.ph == PH_LOAD) |=> dout);

    // R7
    pass_fwd_chk: assert property (@(posedge cclk) disable iff (!rst_n)
        (s_q.ph == PH_PASS) |=> (dout == $past(din)));

    // R9
    done_quiet_chk: assert property (@(posedge cclk) disable iff (!rst_n)
        (s_q.done && $past(s_q.done)) |-> (!fw_en && dout));
endmodule

// File: tb/sim_cfg_chain_fwd.sv
`timescale 1ns/1ps
module sim_cfg_chain_fwd;
    localparam int FB = 32;
    localparam int NF = 4;
    localparam int LB = 24;
    localparam int AW = 2;
    localparam int MAXB = 2048;
    localparam logic [7:0] SYNC = 8'b1111_0010;

    logic          cclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          din = 1'b1;
    logic          dout, fw_en, done, frame_err;
    logic [AW-1:0] fw_addr;
    logic [FB-1:0] fw_data;

    int checks = 0;
    int errors = 0;

    bit          sb  [MAXB];
    bit          se  [MAXB];
    bit          sw  [MAXB];
    int          swa [MAXB];
    logic [31:0] swd [MAXB];
    string       sr  [MAXB];
    int          n;
    int          done_at;
    bit          exp_err;

    always #10 cclk = ~cclk;

    cfg_chain_fwd #(.FRAME_BITS(FB), .NUM_FRAMES(NF), .LEN_BITS(LB)) u0 (
        .cclk(cclk), .rst_n(rst_n), .din(din), .dout(dout),
        .fw_en(fw_en), .fw_addr(fw_addr), .fw_data(fw_data),
        .done(done), .frame_err(frame_err)
    );

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(bit b, bit e, string req);
        sb[n] = b; se[n] = e; sw[n] = 1'b0; sr[n] = req;
        n++;
    endtask

    // Expected stream model built from the requirements.
    task automatic build(int idle, int len, int bad_idx, int trail, bit nearmiss);
        int cnt;
        n = 0; done_at = -1; exp_err = 1'b0; cnt = 0;
        repeat (idle) push(1'b1, 1'b1, "R2");
        if (nearmiss) begin
            for (int k = 7; k >= 0; k--) push(8'b1111_0011 >> k, 8'b1111_0011 >> k, "R2");
        end
        for (int k = 7; k >= 0; k--) push(SYNC[k], SYNC[k], "R2");
        for (int k = LB - 1; k >= 0; k--) push(len[k], len[k], "R3");
        if (len == 0) done_at = n - 1;
        for (int f = 0; f < NF && done_at < 0; f++) begin
            logic [31:0] w;
            w = $urandom;
            for (int j = 0; j < FB + 2 && done_at < 0; j++) begin
                bit b;
                if (j == 0) begin
                    b = (f == bad_idx);
                    if (b) exp_err = 1'b1;
                end else if (j == 1) begin
                    b = 1'b1;
                end else begin
                    b = w[FB + 1 - j];
                end
                push(b, 1'b1, "R4");
                cnt++;
                if (j == FB + 1 && f != bad_idx) begin
                    sw[n-1] = 1'b1; swa[n-1] = f; swd[n-1] = w;
                end
                if (cnt == len) done_at = n - 1;
            end
        end
        while (done_at < 0) begin
            bit b;
            b = $urandom;
            push(b, b, "R7");
            cnt++;
            if (cnt == len) done_at = n - 1;
        end
        repeat (trail) push(bit'($urandom), 1'b1, "R9");
    endtask

    task automatic run();
        logic pre;
        rst_n = 1'b0; din = 1'b1;
        repeat (3) @(posedge cclk);
        #1;
        chk(dout == 1'b1, "R10", "dout in reset", dout, 1);
        @(negedge cclk);
        rst_n = 1'b1;
        #1;
        chk(dout == 1'b1 && done == 1'b0, "R10", "dout/done after reset", {dout, done}, 2'b10);
        chk(frame_err == 1'b0 && fw_en == 1'b0, "R10", "err/we after reset", {frame_err, fw_en}, 0);
        for (int i = 0; i < n; i++) begin
            din = sb[i];
            pre = dout;
            @(posedge cclk);
            #1;
            chk(dout == pre, "R1", "dout moved at rising edge", dout, pre);
            @(negedge cclk);
            #1;
            chk(dout == se[i], sr[i], "dout", dout, se[i]);
            chk(done == (done_at >= 0 && i >= done_at), "R8", "done", done, (i >= done_at));
            if (i > done_at)
                chk(fw_en == 1'b0, "R9", "write after done", fw_en, 0);
            else
                chk(fw_en == sw[i], "R5", "fw_en", fw_en, sw[i]);
            if (sw[i] && fw_en) begin
                chk(fw_addr == AW'(swa[i]), "R5", "fw_addr", fw_addr, swa[i]);
                chk(fw_data == swd[i], "R5", "fw_data", fw_data, swd[i]);
            end
        end
        chk(frame_err == exp_err, "R6", "frame_err", frame_err, exp_err);
    endtask

    initial begin
        #(64'd200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        build(6, NF * (FB + 2) + 25, -1, 12, 1'b1); run();     // R2 near miss, R7 pass
        build(3, NF * (FB + 2) + 10, 2, 8, 1'b0);  run();      // R6 bad frame 2
        build(4, 50, -1, 10, 1'b0);                run();      // R8 ends mid frame
        build(2, 0, -1, 10, 1'b0);                 run();      // R8 zero length
        build(2, NF * (FB + 2), -1, 10, 1'b0);     run();      // R8 ends on last frame bit
        build(2, 60, 0, 6, 1'b0);                  run();      // R6 bad first frame
        repeat (4) begin
            build(1 + int'($urandom % 8), 1 + int'($urandom % 250),
                  int'($urandom % 6), 6, 1'b0);
            run();
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule